// File: doc/BRIEF.md
# Floating-Point Conditional Predicate Evaluator

This block decides whether a floating-point conditional instruction (branch, set-on-condition or conditional trap) is satisfied. A six-bit predicate code is tested against the three stored condition flags of the floating-point unit: not-a-number, zero and negative. All sixteen ordered and unordered IEEE comparisons come from one bit-sliced formula. The block also updates the exception status. A predicate that is not NaN-aware raises the unordered-branch exception when it meets a NaN, and that exception also sets the accrued invalid-operation flag.

The status after the update is compared with an enable mask. If any enabled exception bit is set, the block reports that an exception is taken, so the instruction does not complete. In the same cycle a helper computes the branch target from a short or long displacement. One strobe starts an evaluation, and every output is registered and appears on the next cycle.

Top module: `fp_pred_eval`

## Requirements
- R1: After reset, `valid_o`, `result_o`, `illegal_o`, `trap_o`, `exc_o`, `accr_o` and `target_o` are all zero. `valid_o` is high for exactly the cycle after a cycle in which `eval_i` was high, and low otherwise. All other outputs update in that same cycle.
- R2: With predicate bit 3 clear (ordered), the result is built in three steps. Start from NOT nan. AND it with 0, NOT neg, neg or 1, for bits 2:1 = 00, 01, 10 and 11. Then, if bit 0 is clear, AND with NOT zero; if bit 0 is set, OR with zero.
- R3: With predicate bit 3 set (unordered), the result is built in the same way but starts from 1, and NaN is ORed in at the end, so NaN always gives true.
- R4: Predicate bits 3:0 fix four encodings: 0000 always gives false, 0001 gives the zero flag, 1110 gives NOT zero OR nan, and 1111 always gives true.
- R5: Predicate bit 4 marks a NaN-unaware predicate. When it is set on a legal predicate and nan is set, exception bit 7 (unordered branch) of `exc_o` is set. Otherwise `exc_o` equals `exc_i`.
- R6: On a legal predicate, accrued bit 7 (invalid operation) of `accr_o` is set whenever `exc_o` bit 7 is set. The other accrued bits pass through from `accr_i`.
- R7: On a legal predicate, `trap_o` is high exactly when `exc_o & en_i` is non-zero. This includes an unordered-branch bit raised by the same evaluation.
- R8: A predicate with bit 5 set is illegal. `illegal_o` goes high, `result_o` and `trap_o` are low, and `exc_o`/`accr_o` equal `exc_i`/`accr_i` unchanged.
- R9: When `long_i` is low, the displacement is `disp_hi_i` sign-extended from 16 bits, and `target_o` = `pc_i` + 2 + displacement, modulo 2^32.
- R10: When `long_i` is high, the displacement is {`disp_hi_i`, `disp_lo_i`}, and `target_o` = `pc_i` + 2 + displacement, modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_i | input | 1 | Start one evaluation |
| pred_i | input | 6 | Predicate code |
| cc_nan_i | input | 1 | Stored NaN condition flag |
| cc_zero_i | input | 1 | Stored zero condition flag |
| cc_neg_i | input | 1 | Stored negative condition flag |
| exc_i | input | 8 | Current exception status byte |
| accr_i | input | 8 | Current accrued status byte |
| en_i | input | 8 | Exception enable mask |
| long_i | input | 1 | Select the 32-bit displacement |
| disp_hi_i | input | 16 | Short displacement, or high half of the long one |
| disp_lo_i | input | 16 | Low half of the long displacement |
| pc_i | input | 32 | Instruction address |
| valid_o | output | 1 | Outputs below are fresh |
| result_o | output | 1 | Predicate true |
| illegal_o | output | 1 | Predicate code rejected |
| trap_o | output | 1 | Enabled exception taken |
| exc_o | output | 8 | Updated exception status |
| accr_o | output | 8 | Updated accrued status |
| target_o | output | 32 | Taken branch target |

## Verification
Two functions can fall in the same cycle. A NaN-unaware predicate that meets a NaN raises the unordered-branch bit, and the exception-taken decision must already include that newly raised bit. The bench provokes this by sweeping every predicate code against every flag combination while the enable mask has bit 7 set and the incoming status is clear. It then expects `trap_o` together with `exc_o` bit 7 and `accr_o` bit 7, all in the single result cycle. The same sweep also pairs the illegal-code range with set enables and set status bits, to show that rejection overrides both functions.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  localparam int PRED_W     = 6;
  localparam int UNORD_BIT  = 3;
  localparam int UNAWARE_BIT = 4;
  localparam int ILLEGAL_BIT = 5;
  localparam int STAT_W     = 8;
  localparam int BSUN_BIT   = 7;
  localparam int AIOP_BIT   = 7;

  typedef struct packed {
    logic nan;
    logic zero;
    logic neg;
  } cc_t;
endpackage

// File: rtl/fpe_pred_core.sv
module fpe_pred_core
  import fpe_pkg::*;
(
  input  logic [3:0] code_i,
  input  cc_t        cc_i,
  output logic       hit_o
);
  logic seed, sliced, zstage;

  always_comb begin
    // stage 1: ordered predicates exclude NaN up front
    seed = code_i[UNORD_BIT] ? 1'b1 : ~cc_i.nan;
    // stage 2: sign qualifier
    unique case (code_i[2:1])
      2'b00:   sliced = 1'b0;
      2'b01:   sliced = seed & ~cc_i.neg;
      2'b10:   sliced = seed &  cc_i.neg;
      default: sliced = seed;
    endcase
    // stage 3: equality qualifier
    zstage = code_i[0] ? (sliced | cc_i.zero) : (sliced & ~cc_i.zero);
    // stage 4: unordered predicates accept NaN
    hit_o  = zstage | (code_i[UNORD_BIT] & cc_i.nan);
  end
endmodule

// File: rtl/fpe_status_upd.sv
module fpe_status_upd
  import fpe_pkg::*;
#(
  parameter int SW   = STAT_W,
  parameter int BSUN = BSUN_BIT,
  parameter int AIOP = AIOP_BIT
) (
  input  logic          illegal_i,
  input  logic          unaware_i,
  input  logic          nan_i,
  input  logic [SW-1:0] exc_i,
  input  logic [SW-1:0] accr_i,
  input  logic [SW-1:0] en_i,
  output logic [SW-1:0] exc_o,
  output logic [SW-1:0] accr_o,
  output logic          trap_o
);
  logic [SW-1:0] exc_n, accr_n;

  always_comb begin
    exc_n  = exc_i;
    accr_n = accr_i;
    if (unaware_i && nan_i) exc_n[BSUN] = 1'b1;
    if (exc_n[BSUN])        accr_n[AIOP] = 1'b1;
  end

  assign exc_o  = illegal_i ? exc_i  : exc_n;
  assign accr_o = illegal_i ? accr_i : accr_n;
  assign trap_o = ~illegal_i & (|(exc_n & en_i));
endmodule

// File: rtl/fpe_target_calc.sv
module fpe_target_calc #(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input  logic          long_i,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] lo_i,
  input  logic [AW-1:0] pc_i,
  output logic [AW-1:0] target_o
);
  localparam int LW = 2 * DW;
  logic [AW-1:0] short_x, long_x, disp;

  assign short_x = {{(AW-DW){hi_i[DW-1]}}, hi_i};

  generate
    if (AW > LW) begin : g_wide
      assign long_x = {{(AW-LW){hi_i[DW-1]}}, hi_i, lo_i};
    end else begin : g_fit
      logic [LW-1:0] joined;
      assign joined = {hi_i, lo_i};
      assign long_x = joined[AW-1:0];
    end
  endgenerate

  assign disp     = long_i ? long_x : short_x;
  assign target_o = pc_i + AW'(2) + disp;
endmodule

// File: rtl/fp_pred_eval.sv
module fp_pred_eval
  import fpe_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int SW = STAT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          eval_i,
  input  logic [5:0]    pred_i,
  input  logic          cc_nan_i,
  input  logic          cc_zero_i,
  input  logic          cc_neg_i,
  input  logic [SW-1:0] exc_i,
  input  logic [SW-1:0] accr_i,
  input  logic [SW-1:0] en_i,
  input  logic          long_i,
  input  logic [DW-1:0] disp_hi_i,
  input  logic [DW-1:0] disp_lo_i,
  input  logic [AW-1:0] pc_i,
  output logic          valid_o,
  output logic          result_o,
  output logic          illegal_o,
  output logic          trap_o,
  output logic [SW-1:0] exc_o,
  output logic [SW-1:0] accr_o,
  output logic [AW-1:0] target_o
);
  cc_t           cc;
  logic          hit, bad, trap_c;
  logic [SW-1:0] exc_c, accr_c;
  logic [AW-1:0] tgt_c;

  assign cc  = '{nan: cc_nan_i, zero: cc_zero_i, neg: cc_neg_i};
  assign bad = pred_i[ILLEGAL_BIT];

  fpe_pred_core u_core (
    .code_i (pred_i[3:0]),
    .cc_i   (cc),
    .hit_o  (hit)
  );

  fpe_status_upd #(.SW(SW), .BSUN(BSUN_BIT), .AIOP(AIOP_BIT)) u_stat (
    .illegal_i (bad),
    .unaware_i (pred_i[UNAWARE_BIT]),
    .nan_i     (cc_nan_i),
    .exc_i     (exc_i),
    .accr_i    (accr_i),
    .en_i      (en_i),
    .exc_o     (exc_c),
    .accr_o    (accr_c),
    .trap_o    (trap_c)
  );

  fpe_target_calc #(.AW(AW), .DW(DW)) u_tgt (
    .long_i   (long_i),
    .hi_i     (disp_hi_i),
    .lo_i     (disp_lo_i),
    .pc_i     (pc_i),
    .target_o (tgt_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o   <= 1'b0;
      result_o  <= 1'b0;
      illegal_o <= 1'b0;
      trap_o    <= 1'b0;
      exc_o     <= '0;
      accr_o    <= '0;
      target_o  <= '0;
    end else begin
      valid_o <= eval_i;
      if (eval_i) begin
        result_o  <= hit & ~bad;
        illegal_o <= bad;
        trap_o    <= trap_c;
        exc_o     <= exc_c;
        accr_o    <= accr_c;
        target_o  <= tgt_c;
      end
    end
  end

  // R1: a strobe is answered in the next cycle
  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    eval_i |=> valid_o);
  // R6: a raised unordered-branch bit always carries invalid-operation
  a_r6_aiop_follows: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !illegal_o && exc_o[BSUN_BIT]) |-> accr_o[AIOP_BIT]);
  // R8: an illegal code never reports true or a taken exception
  a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
    (valid_o && illegal_o) |-> (!result_o && !trap_o));
  // R4: code 0000 is never true, code 1111 always true on a legal predicate
  a_r4_false_code: assert property (@(posedge clk) disable iff (rst)
    (eval_i && !pred_i[ILLEGAL_BIT] && pred_i[3:0] == 4'h0) |=> !result_o);
  a_r4_true_code: assert property (@(posedge clk) disable iff (rst)
    (eval_i && !pred_i[ILLEGAL_BIT] && pred_i[3:0] == 4'hF) |=> result_o);
  // R3: an unordered predicate with NaN set is always true
  a_r3_nan_true: assert property (@(posedge clk) disable iff (rst)
    (eval_i && !pred_i[ILLEGAL_BIT] && pred_i[UNORD_BIT] && cc_nan_i) |=> result_o);
  // R7: a trap requires an enabled status bit
  a_r7_trap_enabled: assert property (@(posedge clk) disable iff (rst)
    (eval_i && (en_i == '0)) |=> !trap_o);
  // R5: without a NaN the exception byte passes unchanged
  a_r5_no_nan_pass: assert property (@(posedge clk) disable iff (rst)
    (eval_i && !cc_nan_i) |=> (exc_o == $past(exc_i)));
endmodule

// File: tb/fp_pred_eval_tb_top.sv
`timescale 1ns/1ps
module fp_pred_eval_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        eval_i;
  logic [5:0]  pred_i;
  logic        cc_nan_i, cc_zero_i, cc_neg_i;
  logic [7:0]  exc_i, accr_i, en_i;
  logic        long_i;
  logic [15:0] disp_hi_i, disp_lo_i;
  logic [31:0] pc_i;
  logic        valid_o, result_o, illegal_o, trap_o;
  logic [7:0]  exc_o, accr_o;
  logic [31:0] target_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  fp_pred_eval dut_i (
    .clk, .rst, .eval_i, .pred_i, .cc_nan_i, .cc_zero_i, .cc_neg_i,
    .exc_i, .accr_i, .en_i, .long_i, .disp_hi_i, .disp_lo_i, .pc_i,
    .valid_o, .result_o, .illegal_o, .trap_o, .exc_o, .accr_o, .target_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit ref_pred(input logic [3:0] c, input bit n, input bit z, input bit g);
    case (c)
      4'h0: return 0;
      4'h1: return z;
      4'h2: return !(n | z | g);
      4'h3: return z | !(n | g);
      4'h4: return g & !(n | z);
      4'h5: return z | (g & !n);
      4'h6: return !(n | z);
      4'h7: return z | !n;
      4'h8: return n;
      4'h9: return n | z;
      4'hA: return n | !(g | z);
      4'hB: return n | z | !g;
      4'hC: return n | (g & !z);
      4'hD: return n | z | g;
      4'hE: return n | !z;
      default: return 1;
    endcase
  endfunction

  task automatic run_one;
    @(posedge clk);
    @(negedge clk);
    eval_i = 1'b0;
  endtask

  initial begin
    logic [7:0] vx [5] = '{8'h00, 8'h00, 8'h40, 8'h80, 8'h20};
    logic [7:0] va [5] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01};
    logic [7:0] ve [5] = '{8'h00, 8'h80, 8'h40, 8'h00, 8'h00};
    rst = 1'b1; eval_i = 0; pred_i = 0; cc_nan_i = 0; cc_zero_i = 0; cc_neg_i = 0;
    exc_i = 0; accr_i = 0; en_i = 0; long_i = 0; disp_hi_i = 0; disp_lo_i = 0; pc_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset valid",  {31'd0, valid_o},  0);
    chk("R1 reset result", {31'd0, result_o}, 0);
    chk("R1 reset trap",   {31'd0, trap_o},   0);
    chk("R1 reset exc",    {24'd0, exc_o},    0);
    chk("R1 reset target", target_o,          0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < 5; v++) begin
      for (int p = 0; p < 64; p++) begin
        for (int f = 0; f < 8; f++) begin
          bit ill, nn, res_e, bs, trap_e;
          logic [7:0] xe, ae;
          logic [5:0] pc6;
          pc6 = 6'(p);
          nn = f[2];
          pred_i = pc6; cc_nan_i = f[2]; cc_zero_i = f[1]; cc_neg_i = f[0];
          exc_i = vx[v]; accr_i = va[v]; en_i = ve[v]; eval_i = 1'b1;
          ill = pc6[5];
          res_e = ill ? 1'b0 : ref_pred(pc6[3:0], f[2], f[1], f[0]);
          bs = !ill && pc6[4] && nn;
          xe = vx[v] | (bs ? 8'h80 : 8'h00);
          ae = va[v] | ((!ill && xe[7]) ? 8'h80 : 8'h00);
          trap_e = !ill && ((xe & ve[v]) != 0);
          run_one();
          chk("R1 valid", {31'd0, valid_o}, 1);
          if (ill) chk("R8 result", {31'd0, result_o}, 0);
          else if (pc6[3:0] == 4'h0 || pc6[3:0] == 4'h1 || pc6[3:0] == 4'hE || pc6[3:0] == 4'hF)
            chk("R4 result", {31'd0, result_o}, {31'd0, res_e});
          else if (pc6[3]) chk("R3 result", {31'd0, result_o}, {31'd0, res_e});
          else chk("R2 result", {31'd0, result_o}, {31'd0, res_e});
          chk(ill ? "R8 illegal" : "R8 legal", {31'd0, illegal_o}, {31'd0, ill});
          chk("R5 exc", {24'd0, exc_o}, {24'd0, xe});
          chk("R6 accr", {24'd0, accr_o}, {24'd0, ae});
          chk("R7 trap", {31'd0, trap_o}, {31'd0, trap_e});
        end
      end
    end
    @(negedge clk);
    chk("R1 idle valid", {31'd0, valid_o}, 0);

    // displacement cases
    pred_i = 6'h0F; exc_i = 0; accr_i = 0; en_i = 0;
    pc_i = 32'h0000_1000; long_i = 0; disp_hi_i = 16'h0010; disp_lo_i = 16'hFFFF; eval_i = 1;
    run_one(); chk("R9 short pos", target_o, 32'h0000_1012);
    disp_hi_i = 16'hFFFE; eval_i = 1;
    run_one(); chk("R9 short neg", target_o, 32'h0000_1000);
    pc_i = 32'h0000_0004; disp_hi_i = 16'h8000; eval_i = 1;
    run_one(); chk("R9 short min", target_o, 32'hFFFF_8006);
    pc_i = 32'h1000_0000; long_i = 1; disp_hi_i = 16'h0001; disp_lo_i = 16'h2344; eval_i = 1;
    run_one(); chk("R10 long pos", target_o, 32'h1001_2346);
    disp_hi_i = 16'hFFFF; disp_lo_i = 16'hFFF0; eval_i = 1;
    run_one(); chk("R10 long neg", target_o, 32'h0FFF_FFF2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule